// File: doc/BRIEF.md
# Periodic Tick Interrupt Flag Unit

This block gathers the one-cycle tick strobes produced by a timekeeping divider chain, one strobe for each rate (for example one per second or one per minute), and keeps them in two levels of flags. The lower level is a bank of per-rate flags. Each flag is set by its own tick whether or not that rate can interrupt, and the whole bank clears on any read or write access to it. The upper level is a single summary flag in the main status word. A tick on any rate whose enable bit is set raises the summary flag, and only an explicit write of a one to that bit lowers it again.

The summary flag drives one of two active-high interrupt pins. A route select input chooses between them: one is the main interrupt line and the other is a multi-function line. Clearing the per-rate flags never cancels a pending interrupt. Turning off every enable does not cancel it either, so a pending interrupt always has to be acknowledged through the status write.

Top module: `pti_unit`

## Requirements
- R1: After a synchronous reset, all per-rate flags, the summary flag and both interrupt pins read 0.
- R2: A tick on rate i (`tick_i[i]` high for one cycle) sets `pflag_o[i]` from the next cycle onward, whatever the value of `rate_en_i[i]`.
- R3: A cycle with `pflag_rd_i` or `pflag_wr_i` high clears every bit of `pflag_o` in the next cycle.
- R4: When a tick arrives in the same cycle as a per-rate flag access, the flag of that rate reads 1 in the next cycle, and the other flags read 0.
- R5: A tick on a rate whose enable bit is 1 sets `sum_flag_o` in the next cycle. Ticks on rates whose enable bit is 0 leave a cleared `sum_flag_o` at 0.
- R6: `sum_flag_o` clears in the next cycle only when `stat_wr_i` is high with `stat_wbit_i` equal to 1. A status write of 0 and any per-rate flag access leave it set.
- R7: With `sum_flag_o` set, clearing all bits of `rate_en_i` leaves it set until a write of one.
- R8: When an enabled tick coincides with a write of one, `sum_flag_o` reads 1 in the next cycle.
- R9: With `route_mfo_i` = 0, `irq_main_o` equals `sum_flag_o` and `irq_mfo_o` is 0. With `route_mfo_i` = 1, `irq_mfo_o` equals `sum_flag_o` and `irq_main_o` is 0.
- R10: With no tick and no access, every per-rate flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 6 | One-cycle tick strobes, one per rate |
| rate_en_i | input | 6 | Per-rate interrupt enable bits |
| route_mfo_i | input | 1 | 0 routes to the main interrupt pin, 1 routes to the multi-function pin |
| pflag_rd_i | input | 1 | Read strobe for the per-rate flag register |
| pflag_wr_i | input | 1 | Write strobe for the per-rate flag register (the data is ignored) |
| stat_wr_i | input | 1 | Write strobe for the summary flag bit of the status word |
| stat_wbit_i | input | 1 | Data for the summary flag bit; 1 clears it |
| pflag_o | output | 6 | Per-rate flag register contents |
| sum_flag_o | output | 1 | Summary periodic flag |
| irq_main_o | output | 1 | Main interrupt pin, active high |
| irq_mfo_o | output | 1 | Multi-function pin, active high |

## Verification
Checks that run on every cycle cover the following. A tick always lands in its per-rate flag. An access leaves behind only the ticks of that same cycle. An enabled tick always raises the summary flag. The summary flag never falls without a write of one, and never rises without an enabled tick. The two interrupt pins are never high together. Other behaviour needs the bench's scenarios to show it. The full sweep crosses every tick pattern with every enable pattern. A pending interrupt survives a write of zero, a per-rate access and the removal of every enable. Each set-versus-clear collision resolves in favour of the set.

// File: rtl/pti_pkg.sv
`timescale 1ns/1ps
package pti_pkg;

    localparam int PTI_RATES = 6;

    typedef enum logic {
        ROUTE_MAIN = 1'b0,
        ROUTE_MFO  = 1'b1
    } route_e;

    typedef struct packed {
        logic main;
        logic mfo;
    } irq_pins_t;

    // Steer a level onto one of the two interrupt pins.
    function automatic irq_pins_t steer(input logic level, input route_e sel);
        irq_pins_t p;
        p.main = level & (sel == ROUTE_MAIN);
        p.mfo  = level & (sel == ROUTE_MFO);
        return p;
    endfunction

endpackage

// File: rtl/pti_rate_flags.sv
`timescale 1ns/1ps
module pti_rate_flags #(
    parameter int N = pti_pkg::PTI_RATES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tick,
    input  logic         access,
    output logic [N-1:0] flags
);
    // One sticky bit per rate. When a tick and a clear arrive together, the tick wins.
    for (genvar i = 0; i < N; i++) begin : g_rate
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (tick[i])
                bit_q <= 1'b1;
            else if (access)
                bit_q <= 1'b0;
        end
        assign flags[i] = bit_q;
    end
endmodule

// File: rtl/pti_summary.sv
`timescale 1ns/1ps
module pti_summary #(
    parameter int N = pti_pkg::PTI_RATES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tick,
    input  logic [N-1:0] enable,
    input  logic         ack,
    output logic         pending
);
    logic hit;
    logic pend_q;

    assign hit = |(tick & enable);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (hit)
            pend_q <= 1'b1;
        else if (ack)
            pend_q <= 1'b0;
    end

    assign pending = pend_q;
endmodule

// File: rtl/pti_route.sv
`timescale 1ns/1ps
module pti_route (
    input  logic level,
    input  logic sel_mfo,
    output logic pin_main,
    output logic pin_mfo
);
    import pti_pkg::*;
    irq_pins_t pins;
    route_e    sel;

    assign sel      = sel_mfo ? ROUTE_MFO : ROUTE_MAIN;
    assign pins     = steer(level, sel);
    assign pin_main = pins.main;
    assign pin_mfo  = pins.mfo;
endmodule

// File: rtl/pti_unit.sv
`timescale 1ns/1ps
module pti_unit #(
    parameter int N = pti_pkg::PTI_RATES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tick_i,
    input  logic [N-1:0] rate_en_i,
    input  logic         route_mfo_i,
    input  logic         pflag_rd_i,
    input  logic         pflag_wr_i,
    input  logic         stat_wr_i,
    input  logic         stat_wbit_i,
    output logic [N-1:0] pflag_o,
    output logic         sum_flag_o,
    output logic         irq_main_o,
    output logic         irq_mfo_o
);
    logic flag_access;
    logic sum_ack;

    assign flag_access = pflag_rd_i | pflag_wr_i;
    assign sum_ack     = stat_wr_i & stat_wbit_i;

    pti_rate_flags #(.N(N)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_i),
        .access (flag_access),
        .flags  (pflag_o)
    );

    pti_summary #(.N(N)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_i),
        .enable  (rate_en_i),
        .ack     (sum_ack),
        .pending (sum_flag_o)
    );

    pti_route u_route (
        .level    (sum_flag_o),
        .sel_mfo  (route_mfo_i),
        .pin_main (irq_main_o),
        .pin_mfo  (irq_mfo_o)
    );
endmodule

// File: rtl/pti_unit_chk.sv
`timescale 1ns/1ps
module pti_unit_chk #(
    parameter int N = pti_pkg::PTI_RATES
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] tick_i,
    input logic [N-1:0] rate_en_i,
    input logic         pflag_rd_i,
    input logic         pflag_wr_i,
    input logic         stat_wr_i,
    input logic         stat_wbit_i,
    input logic [N-1:0] pflag_o,
    input logic         sum_flag_o,
    input logic         irq_main_o,
    input logic         irq_mfo_o
);
    // R2 and R4: every tick shows up in its flag on the next cycle.
    p_tick_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (|tick_i) |=> ((pflag_o & $past(tick_i)) == $past(tick_i)));

    // R3: after an access, only the ticks of that same cycle remain.
    p_access_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (pflag_rd_i || pflag_wr_i) |=> (pflag_o == $past(tick_i)));

    // R10: flags hold when there is no tick and no access.
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!(|tick_i) && !pflag_rd_i && !pflag_wr_i) |=> $stable(pflag_o));

    // R5 and R8: an enabled tick always raises the summary flag.
    p_sum_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (|(tick_i & rate_en_i)) |=> sum_flag_o);

    // R5: the summary flag never rises without an enabled tick.
    p_sum_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        (!sum_flag_o && !(|(tick_i & rate_en_i))) |=> !sum_flag_o);

    // R6 and R7: only a write of one lowers the summary flag.
    p_sum_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (sum_flag_o && !(stat_wr_i && stat_wbit_i)) |=> sum_flag_o);

    // R9: the two pins are never high together, and neither is high without the flag.
    p_route_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(irq_main_o && irq_mfo_o) && ((irq_main_o || irq_mfo_o) == sum_flag_o));
endmodule

bind pti_unit pti_unit_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .rate_en_i   (rate_en_i),
    .pflag_rd_i  (pflag_rd_i),
    .pflag_wr_i  (pflag_wr_i),
    .stat_wr_i   (stat_wr_i),
    .stat_wbit_i (stat_wbit_i),
    .pflag_o     (pflag_o),
    .sum_flag_o  (sum_flag_o),
    .irq_main_o  (irq_main_o),
    .irq_mfo_o   (irq_mfo_o)
);

// File: tb/tb_pti_unit.sv
`timescale 1ns/1ps
module tb_pti_unit;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] tick_i;
    logic [N-1:0] rate_en_i;
    logic         route_mfo_i;
    logic         pflag_rd_i;
    logic         pflag_wr_i;
    logic         stat_wr_i;
    logic         stat_wbit_i;
    logic [N-1:0] pflag_o;
    logic         sum_flag_o;
    logic         irq_main_o;
    logic         irq_mfo_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pti_unit #(.N(N)) dut (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .rate_en_i   (rate_en_i),
        .route_mfo_i (route_mfo_i),
        .pflag_rd_i  (pflag_rd_i),
        .pflag_wr_i  (pflag_wr_i),
        .stat_wr_i   (stat_wr_i),
        .stat_wbit_i (stat_wbit_i),
        .pflag_o     (pflag_o),
        .sum_flag_o  (sum_flag_o),
        .irq_main_o  (irq_main_o),
        .irq_mfo_o   (irq_mfo_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock edge. Inputs change, and outputs are sampled, 1 ns after the edge.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tick_i = '0; pflag_rd_i = 0; pflag_wr_i = 0; stat_wr_i = 0; stat_wbit_i = 0;
    endtask

    task automatic chk_pins(input string req, input logic route, input logic sum_exp);
        chk(req, int'(irq_main_o), int'(sum_exp & ~route));
        chk(req, int'(irq_mfo_o),  int'(sum_exp & route));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rate_en_i = '0; route_mfo_i = 0; rst = 1;
        cyc(); cyc();
        rst = 0;
        // R1: state right after reset
        chk("R1 pflag", int'(pflag_o), 0);
        chk("R1 sum", int'(sum_flag_o), 0);
        chk("R1 main", int'(irq_main_o), 0);
        chk("R1 mfo", int'(irq_mfo_o), 0);

        // Full sweep: every enable pattern against every tick pattern (R2, R5, R9, R3, R6)
        for (int e = 0; e < (1 << N); e++) begin
            for (int t = 0; t < (1 << N); t++) begin
                logic route;
                logic sexp;
                route = logic'((t ^ e) & 1);
                sexp  = ((t & e) != 0);
                rate_en_i = N'(e); tick_i = N'(t); route_mfo_i = route;
                cyc();
                tick_i = '0;
                chk("R2 sweep pflag", int'(pflag_o), t);
                chk("R5 sweep sum", int'(sum_flag_o), int'(sexp));
                chk_pins("R9 sweep pins", route, sexp);
                pflag_rd_i = 1; stat_wr_i = 1; stat_wbit_i = 1;
                cyc();
                idle();
                chk("R3 sweep clear", int'(pflag_o), 0);
                chk("R6 sweep ack", int'(sum_flag_o), 0);
            end
        end

        // R10: flags hold across idle cycles
        rate_en_i = '0; tick_i = 6'b100101; cyc(); idle();
        cyc(); cyc(); cyc();
        chk("R10 hold", int'(pflag_o), 6'b100101);
        // R3: a write access clears as well
        pflag_wr_i = 1; cyc(); idle();
        chk("R3 write clears", int'(pflag_o), 0);
        // R4: a tick during an access survives the clear
        tick_i = 6'b000011; cyc(); idle();
        tick_i = 6'b010000; pflag_rd_i = 1; cyc(); idle();
        chk("R4 tick beats clear", int'(pflag_o), 6'b010000);
        pflag_rd_i = 1; cyc(); idle();

        // R6: a write of zero and per-rate accesses leave the summary set
        rate_en_i = 6'b001000; route_mfo_i = 0;
        tick_i = 6'b001000; cyc(); idle();
        chk("R6 set", int'(sum_flag_o), 1);
        stat_wr_i = 1; stat_wbit_i = 0; cyc(); idle();
        chk("R6 write zero", int'(sum_flag_o), 1);
        pflag_rd_i = 1; cyc(); idle();
        pflag_wr_i = 1; cyc(); idle();
        chk("R6 pflag access", int'(sum_flag_o), 1);
        chk("R6 pflag cleared", int'(pflag_o), 0);
        chk_pins("R9 pending main", 1'b0, 1'b1);
        // R7: removing every enable keeps it pending
        rate_en_i = '0; cyc(); cyc();
        chk("R7 enables off", int'(sum_flag_o), 1);
        route_mfo_i = 1; #0.5;
        chk_pins("R9 reroute", 1'b1, 1'b1);
        stat_wr_i = 1; stat_wbit_i = 1; cyc(); idle();
        chk("R7 ack", int'(sum_flag_o), 0);
        chk_pins("R9 after ack", 1'b1, 1'b0);

        // R8: an enabled tick together with a write of one leaves it set
        rate_en_i = 6'b000001;
        tick_i = 6'b000001; stat_wr_i = 1; stat_wbit_i = 1; cyc(); idle();
        chk("R8 set beats ack", int'(sum_flag_o), 1);
        // A disabled tick together with a write of one clears it
        tick_i = 6'b000010; stat_wr_i = 1; stat_wbit_i = 1; cyc(); idle();
        chk("R8 disabled tick ack", int'(sum_flag_o), 0);

        // R1: a reset in mid-operation clears everything
        tick_i = '1; rate_en_i = '1; cyc(); idle();
        rst = 1; cyc(); rst = 0;
        chk("R1 mid reset pflag", int'(pflag_o), 0);
        chk("R1 mid reset sum", int'(sum_flag_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule